// File: doc/BRIEF.md
# Two-wire byte-access slave with auto-incrementing pointer

This block is a slave on a two-wire serial bus (SCL clock line, SDA data line). It opens a 64-byte address space, holding timekeeping registers and general-purpose RAM, to a bus master, one byte at a time and in sequence. Both bus lines are oversampled by the system clock. They pass through a synchronizer and a stable-count glitch filter. The engine then detects START and STOP conditions, matches a fixed device address, acknowledges bytes and shifts data. It drives SDA only through an open-drain output enable: `sda_oe` high means "pull SDA low".

A write transfer first loads a word pointer. Every data byte that follows is presented on the internal register-file port. A read transfer returns bytes from the pointer for as long as the master acknowledges. The pointer advances after every data byte and wraps at the top of the space, so there is no limit on burst length. A supply-fail input aborts any access, releases the bus, clears the pointer and blinds the engine to the bus while it is held.

The register-file port is a one-way stream. `mem_wr_valid` qualifies `mem_addr`/`mem_wdata` for exactly one cycle, and there is no ready. The slave cannot stretch SCL, so it cannot hold a byte back, and the register file must take every strobe. Read data is combinational: `mem_rdata` must show the byte at `mem_addr` in the same cycle.

Top module: `tw_slave_mem`

## Requirements
- R1: The address byte (first byte after START, MSB first) is acknowledged only when it is D0h (write) or D1h (read). The slave acknowledges by driving SDA low (`sda_oe`=1) for the ninth clock. For any other address the slave never drives SDA and produces no writes until the next START.
- R2: In a write transfer, the first byte after the address loads its low 6 bits into the pointer and produces no write strobe. Each later byte is acknowledged and produces one single-cycle `mem_wr_valid` with `mem_addr` equal to the pointer, after which the pointer advances by one.
- R3: The pointer wraps from 63 to 0, for writes and for reads alike, so a burst of any length continues across the wrap.
- R4: In a read transfer, each byte is the register-file content at the pointer, shifted out MSB first while SCL is low. The pointer advances by one per byte, and transfer continues while the master acknowledges (SDA low on the ninth clock).
- R5: After the master does not acknowledge a read byte (SDA high on the ninth clock), the slave leaves SDA undriven until the next START or STOP.
- R6: A START seen in the middle of a transfer (repeated START) returns the slave to address matching and leaves the pointer unchanged.
- R7: While `supply_fail` is high, the access in progress ends, `sda_oe` is 0 from the next cycle, the pointer is 0 from the next cycle, and no bus activity produces a write or an acknowledge.
- R8: A level on SCL or SDA that lasts fewer than FILT_CYC system clocks is ignored. A short SCL pulse does not count as a bit, and a short SDA dip while SCL is high is not a START.
- R9: Out of reset and after STOP, the slave is idle with `sda_oe`=0 and no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_fail | input | 1 | Supply out of tolerance: abort, clear pointer, ignore bus |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level (resolved bus value) |
| sda_oe | output | 1 | Pull SDA low when 1 (open drain) |
| mem_addr | output | ADDR_W | Word pointer; register-file address for reads and writes |
| mem_wr_valid | output | 1 | One-cycle write strobe, no ready |
| mem_wdata | output | 8 | Write data, valid with mem_wr_valid |
| mem_rdata | input | 8 | Register-file byte at mem_addr, combinational |

## Verification
Two actions can land on the pointer in the same cycle: the advance after a write strobe, and the clear from `supply_fail`. The clear takes precedence. The checker judges that cycle directly: a strobe without a fail must be followed by pointer+1, and a fail must be followed by pointer 0 and no strobe. The bench raises the fail while the slave is driving a read bit, then runs a whole write transfer with the fail still held. It judges the outcome at the ports: the bus is released, no strobe appears, no acknowledge is given, and the next read returns byte 0.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_WR,
    ST_RX_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_HOLD
  } tw_state_e;
endpackage

// File: rtl/tw_glitch_filt.sv
`timescale 1ns/1ps
module tw_glitch_filt #(
  parameter int W        = 2,
  parameter int FILT_CYC = 100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] filt
);
  localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FILT_CYC - 1);

  for (genvar g = 0; g < W; g++) begin : g_line
    logic          s1, s2, lvl;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1  <= 1'b1;
        s2  <= 1'b1;
        lvl <= 1'b1;
        cnt <= '0;
      end else begin
        s1 <= raw[g];
        s2 <= s1;
        if (s2 == lvl) begin
          cnt <= '0;
        end else if (cnt == LIMIT) begin
          lvl <= s2;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    assign filt[g] = lvl;
  end
endmodule

// File: rtl/tw_bus_events.sv
`timescale 1ns/1ps
module tw_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/tw_engine.sv
`timescale 1ns/1ps
module tw_engine
  import tw_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter logic [6:0]  DEV_ADDR = 7'h68
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_fail,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_s,
  input  logic [BYTE_W-1:0] rdata,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] ptr,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wdata
);
  tw_state_e         state;
  logic [BYTE_W-1:0] shreg;
  logic [2:0]        bitcnt;
  logic              got8;
  logic              is_read;
  logic              mnack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      bitcnt   <= '0;
      got8     <= 1'b0;
      is_read  <= 1'b0;
      mnack    <= 1'b1;
      sda_oe   <= 1'b0;
      ptr      <= '0;
      wr_valid <= 1'b0;
      wdata    <= '0;
    end else if (supply_fail) begin
      state    <= ST_IDLE;
      sda_oe   <= 1'b0;
      ptr      <= '0;
      wr_valid <= 1'b0;
      got8     <= 1'b0;
      bitcnt   <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (wr_valid) ptr <= ptr + 1'b1;

      if (stop_ev) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
        got8   <= 1'b0;
      end else if (start_ev) begin
        state  <= ST_ADDR;
        sda_oe <= 1'b0;
        bitcnt <= '0;
        got8   <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_PTR, ST_WR: begin
            if (scl_rise) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == 3'd7) got8 <= 1'b1;
            end else if (scl_fall && got8) begin
              got8 <= 1'b0;
              if (state == ST_ADDR) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  sda_oe  <= 1'b1;
                  is_read <= shreg[0];
                  state   <= ST_ADDR_ACK;
                end else begin
                  state <= ST_HOLD;
                end
              end else if (state == ST_PTR) begin
                ptr    <= shreg[ADDR_W-1:0];
                sda_oe <= 1'b1;
                state  <= ST_RX_ACK;
              end else begin
                wr_valid <= 1'b1;
                wdata    <= shreg;
                sda_oe   <= 1'b1;
                state    <= ST_RX_ACK;
              end
            end
          end

          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (is_read) begin
                shreg  <= rdata;
                sda_oe <= ~rdata[7];
                ptr    <= ptr + 1'b1;
                state  <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_PTR;
              end
            end
          end

          ST_RX_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_WR;
            end
          end

          ST_RD: begin
            if (scl_fall) begin
              if (bitcnt == 3'd7) begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                state  <= ST_RD_ACK;
              end else begin
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~shreg[6];
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end

          ST_RD_ACK: begin
            if (scl_rise) begin
              mnack <= sda_s;
            end else if (scl_fall) begin
              if (!mnack) begin
                shreg  <= rdata;
                sda_oe <= ~rdata[7];
                ptr    <= ptr + 1'b1;
                bitcnt <= '0;
                state  <= ST_RD;
              end else begin
                state <= ST_HOLD;
              end
            end
          end

          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tw_slave_mem.sv
`timescale 1ns/1ps
module tw_slave_mem
  import tw_pkg::*;
#(
  parameter int         ADDR_W   = 6,
  parameter int         FILT_CYC = 100,
  parameter logic [6:0] DEV_ADDR = 7'h68
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_fail,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr_valid,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  logic [1:0] line_f;
  logic       scl_f, sda_f;
  logic       scl_rise, scl_fall, start_ev, stop_ev;

  tw_glitch_filt #(.W(2), .FILT_CYC(FILT_CYC)) u_filt (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  ({scl_in, sda_in}),
    .filt (line_f)
  );

  assign scl_f = line_f[1];
  assign sda_f = line_f[0];

  tw_bus_events u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (scl_f),
    .sda_f   (sda_f),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  tw_engine #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_fail(supply_fail),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_ev   (start_ev),
    .stop_ev    (stop_ev),
    .sda_s      (sda_f),
    .rdata      (mem_rdata),
    .sda_oe     (sda_oe),
    .ptr        (mem_addr),
    .wr_valid   (mem_wr_valid),
    .wdata      (mem_wdata)
  );
endmodule

// File: rtl/tw_slave_mem_chk.sv
`timescale 1ns/1ps
module tw_slave_mem_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              supply_fail,
  input logic              sda_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_wr_valid,
  input logic              scl_f
);
  assert_fail_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    supply_fail |=> !sda_oe)
    else $error("R7: SDA still driven after supply fail");

  assert_fail_ptr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    supply_fail |=> (mem_addr == '0))
    else $error("R7: pointer not cleared by supply fail");

  assert_fail_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_fail && $past(supply_fail)) |-> !mem_wr_valid)
    else $error("R7: write strobe while supply fail held");

  assert_wr_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |=> !mem_wr_valid)
    else $error("R2: write strobe longer than one cycle");

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !supply_fail) |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)))
    else $error("R3: pointer did not advance by one after a write");

  assert_oe_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(supply_fail)) |-> !scl_f)
    else $error("R1: SDA drive changed while SCL high");
endmodule

bind tw_slave_mem tw_slave_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .supply_fail (supply_fail),
  .sda_oe      (sda_oe),
  .mem_addr    (mem_addr),
  .mem_wr_valid(mem_wr_valid),
  .scl_f       (scl_f)
);

// File: tb/sim_tw_slave_mem.sv
`timescale 1ns/1ps
module sim_tw_slave_mem;
  localparam int AW   = 6;
  localparam int NW   = 1 << AW;
  localparam int FILT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_fail = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [AW-1:0] mem_addr;
  logic mem_wr_valid;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata;
  logic sda_bus;

  logic [7:0] regs [NW];
  logic [7:0] exp_m [NW];
  int exp_ptr = 0;
  int n_chk = 0;
  int n_fail = 0;
  int wr_cnt = 0;
  int oe_cnt = 0;
  int gl_mode = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_bus   = sda_m & ~sda_oe;
  assign mem_rdata = regs[mem_addr];

  always @(posedge clk) begin
    if (mem_wr_valid) begin
      regs[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (sda_oe) oe_cnt <= oe_cnt + 1;
  end

  tw_slave_mem #(.ADDR_W(AW), .FILT_CYC(FILT), .DEV_ADDR(7'h68)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_fail(supply_fail),
    .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
    .mem_addr(mem_addr), .mem_wr_valid(mem_wr_valid),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one bit slot, entered and left with SCL low; low and high phases of 20 clocks each
  task automatic bit_slot(input logic b, output logic r);
    wclk(8);
    if (gl_mode == 1) begin scl_m = 1'b1; wclk(2); scl_m = 1'b0; end
    else wclk(2);
    sda_m = b;
    wclk(10);
    scl_m = 1'b1;
    wclk(5);
    if (gl_mode == 2 && b) begin sda_m = 1'b0; wclk(2); sda_m = 1'b1; wclk(3); end
    else wclk(5);
    r = sda_bus;
    wclk(10);
    scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(10);
    scl_m = 1'b1; wclk(20);
    sda_m = 1'b0; wclk(20);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wclk(10); sda_m = 1'b0;
    wclk(10); scl_m = 1'b1;
    wclk(20); sda_m = 1'b1;
    wclk(20);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_slot(b[i], r);
    bit_slot(1'b1, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_slot(1'b1, r);
      d[i] = r;
    end
    bit_slot(~mack, r);
  endtask

  task automatic set_ptr(input int p);
    logic a;
    bus_start();
    wr_byte(8'hD0, a); check(a, "R1 write address ack", a, 1);
    wr_byte(8'(p), a); check(a, "R2 pointer byte ack", a, 1);
    bus_stop();
    exp_ptr = p % NW;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    int w0, o0;
    for (int i = 0; i < NW; i++) begin
      regs[i]  = 8'((i * 37 + 5) % 256);
      exp_m[i] = 8'((i * 37 + 5) % 256);
    end
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    // R9: reset state
    check(sda_oe == 1'b0, "R9 reset sda_oe", sda_oe, 0);
    check(mem_wr_valid == 1'b0, "R9 reset write strobe", mem_wr_valid, 0);
    check(mem_addr == '0, "R9 reset pointer", mem_addr, 0);

    // R1: address sweep around the device address
    w0 = wr_cnt;
    for (int b = 8'hC8; b <= 8'hD7; b++) begin
      bus_start();
      o0 = oe_cnt;
      wr_byte(8'(b), a);
      check(a == (b == 8'hD0 || b == 8'hD1), "R1 address ack", a, (b == 8'hD0 || b == 8'hD1));
      if (b == 8'hD0) begin
        wr_byte(8'h00, a);
        check(a, "R2 pointer byte ack", a, 1);
        exp_ptr = 0;
      end else if (b == 8'hD1) begin
        rd_byte(1'b0, d);
        check(d == exp_m[exp_ptr], "R4 read after sweep", d, exp_m[exp_ptr]);
        exp_ptr = (exp_ptr + 1) % NW;
      end else begin
        wr_byte(8'h00, a);
        check(a == 1'b0 && oe_cnt == o0, "R1 no drive for foreign address", oe_cnt - o0, 0);
      end
      bus_stop();
      check(sda_oe == 1'b0, "R9 idle after stop", sda_oe, 0);
    end
    check(wr_cnt == w0, "R1 R2 no writes during sweep", wr_cnt - w0, 0);

    // R2 R3: 64-byte write burst starting at 60, wraps through 63 -> 0
    w0 = wr_cnt;
    bus_start();
    wr_byte(8'hD0, a); check(a, "R1 write address ack", a, 1);
    wr_byte(8'd60, a); check(a, "R2 pointer byte ack", a, 1);
    exp_ptr = 60;
    for (int k = 0; k < NW; k++) begin
      logic [7:0] v;
      v = 8'((k * 29 + 11) % 256);
      wr_byte(v, a);
      check(a, "R2 data byte ack", a, 1);
      exp_m[exp_ptr] = v;
      exp_ptr = (exp_ptr + 1) % NW;
    end
    bus_stop();
    check(wr_cnt - w0 == NW, "R2 one strobe per data byte", wr_cnt - w0, NW);
    check(mem_addr == AW'(exp_ptr), "R3 pointer after wrap", mem_addr, exp_ptr);

    // R4 R3: 64-byte read burst from the current pointer
    bus_start();
    wr_byte(8'hD1, a); check(a, "R1 read address ack", a, 1);
    for (int k = 0; k < NW; k++) begin
      rd_byte(k != NW - 1, d);
      check(d == exp_m[exp_ptr], "R4 R3 read burst data", d, exp_m[exp_ptr]);
      exp_ptr = (exp_ptr + 1) % NW;
    end
    // R5: after master NACK the slave stays off the bus
    o0 = oe_cnt;
    wr_byte(8'h00, a);
    check(oe_cnt == o0 && a == 1'b0, "R5 no drive after NACK", oe_cnt - o0, 0);
    bus_stop();

    // R6: repeated START keeps the pointer
    bus_start();
    wr_byte(8'hD0, a); check(a, "R1 write address ack", a, 1);
    wr_byte(8'd10, a); check(a, "R2 pointer byte ack", a, 1);
    wr_byte(8'h5A, a); check(a, "R2 data byte ack", a, 1);
    exp_m[10] = 8'h5A;
    bus_start();
    wr_byte(8'hD1, a); check(a, "R6 read address after repeated start", a, 1);
    rd_byte(1'b0, d);
    check(d == exp_m[11], "R6 pointer kept over repeated start", d, exp_m[11]);
    bus_start();
    wr_byte(8'hD1, a); check(a, "R6 second repeated start ack", a, 1);
    rd_byte(1'b0, d);
    check(d == exp_m[12], "R6 pointer kept again", d, exp_m[12]);
    bus_stop();
    check(regs[10] == 8'h5A, "R2 written byte landed", regs[10], 8'h5A);

    // R8: glitches on SCL during low phase and on SDA during high phase
    bus_start();
    wr_byte(8'hD0, a); check(a, "R1 write address ack", a, 1);
    gl_mode = 1;
    wr_byte(8'h25, a);
    gl_mode = 0;
    check(a, "R8 pointer byte ack with SCL glitches", a, 1);
    gl_mode = 2;
    wr_byte(8'hB6, a);
    gl_mode = 0;
    check(a, "R8 data byte ack with SDA glitches", a, 1);
    bus_stop();
    exp_m[37] = 8'hB6;
    check(regs[37] == 8'hB6, "R8 glitched write landed", regs[37], 8'hB6);

    // R7: supply fail while slave drives a read bit
    bus_start();
    wr_byte(8'hD0, a);
    wr_byte(8'd50, a);
    wr_byte(8'h3C, a);
    check(a, "R2 data byte ack", a, 1);
    bus_stop();
    exp_m[50] = 8'h3C;
    set_ptr(50);
    bus_start();
    wr_byte(8'hD1, a); check(a, "R1 read address ack", a, 1);
    wclk(14);
    check(sda_oe == 1'b1, "R4 drives MSB zero", sda_oe, 1);
    supply_fail = 1'b1;
    wclk(2);
    check(sda_oe == 1'b0, "R7 bus released on supply fail", sda_oe, 0);
    check(mem_addr == '0, "R7 pointer cleared", mem_addr, 0);
    w0 = wr_cnt;
    o0 = oe_cnt;
    bus_stop();
    bus_start();
    wr_byte(8'hD0, a); check(a == 1'b0, "R7 no ack while fail", a, 0);
    wr_byte(8'h05, a); check(a == 1'b0, "R7 no ack while fail", a, 0);
    wr_byte(8'h99, a); check(a == 1'b0, "R7 no ack while fail", a, 0);
    bus_stop();
    check(wr_cnt == w0 && oe_cnt == o0, "R7 bus ignored while fail", wr_cnt - w0, 0);
    supply_fail = 1'b0;
    wclk(20);
    bus_start();
    wr_byte(8'hD1, a); check(a, "R1 read address ack", a, 1);
    rd_byte(1'b0, d);
    check(d == exp_m[0], "R7 read from cleared pointer", d, exp_m[0]);
    bus_stop();
    check(regs[5] == exp_m[5], "R7 ignored write left byte", regs[5], exp_m[5]);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule